// File: doc/BRIEF.md
# BPSK-over-MSK Chip Sequence Encoder

This encoder sits between a slow serial data source and the synchronous serial data input of a radio transceiver. The transceiver offers minimum-shift keying (MSK) as its only phase-continuous modulation. The encoder spreads each data bit over a fixed number of MSK symbols, called chips. Its default is 10 chips per bit, and a parameter sets the ratio because the data rate is far below the chip rate.

While the data stays constant, every chip is 0. The receiver therefore locks onto the chip-0 tone as its carrier reference. When a new data bit differs from the previous one, in either direction, the first chip of that bit's group is 1 and the rest are 0. That single chip advances the carrier phase by 180° against the reference. The radiated signal is therefore binary phase-shift keyed by the data, which is sent differentiated in time.

The transceiver supplies a one-cycle chip enable for each chip. The data source offers bits through a valid/ready handshake, and a bit is taken only in the last chip slot of a group. When no bit is offered at that point, the encoder emits chip 0 and drops busy. It keeps the last data bit, so the phase stays continuous when data resumes.

Top module: `bpsk_chip_encoder`

## Requirements
- R1: After reset, sym_out is 0 and busy is 0, and in_ready equals sym_en (the encoder starts in its idle, end-of-group state).
- R2: in_ready is 1 only in a cycle where sym_en is 1 and the current group is in its last chip slot, or the encoder is idle. A bit is accepted on a clock edge where in_valid and in_ready are both 1.
- R3: When an accepted bit differs from the previously accepted bit, sym_out becomes 1 for the first chip slot of the new group.
- R4: When an accepted bit equals the previously accepted bit, sym_out stays 0 for the first chip slot.
- R5: Chip slots 2 to CHIPS_PER_BIT of every group carry sym_out = 0, so each group holds at most one chip of value 1.
- R6: The remembered previous bit resets to 0, so a first accepted bit of 1 produces a chip of value 1.
- R7: If no bit is valid when the last slot ends, sym_out is 0 and busy is 0 until a bit is accepted. The previous bit is kept across the idle time: a resumed bit equal to it gives no chip of value 1.
- R8: sym_out and busy change only on clock edges where sym_en is 1.
- R9: A group lasts exactly CHIPS_PER_BIT chip enables: busy is 1 from the accept edge, and in_ready next rises on the CHIPS_PER_BIT-th enable after the accept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | Data bit value |
| in_ready | output | 1 | Bit is taken at this edge if in_valid is 1 |
| sym_en | input | 1 | One-cycle chip enable from the transceiver |
| sym_out | output | 1 | Current MSK chip value to the transceiver |
| busy | output | 1 | A data group is being sent |

## Verification
A wrong slot count shows at the ports within one group: in_ready rises too early or too late relative to the tenth enable, and a misplaced chip of value 1 lands outside the first slot. A corrupted previous-bit register shows at the next accepted bit, as a missing or extra chip of value 1 in that group's first slot. A wrong busy or idle state appears on the first enable after a group ends without data. Stimulus mixes directed bit patterns with random enable spacing, random data and random gaps, all compared against a per-chip model.

// File: rtl/bpsk_enc_pkg.sv
package bpsk_enc_pkg;
  // Event handed from the handshake point to the output stage
  typedef struct packed {
    logic take;  // a data bit is accepted at this edge
    logic flip;  // the accepted bit differs from the previous one
  } grp_evt_t;
endpackage

// File: rtl/chip_slot_counter.sv
module chip_slot_counter #(
  parameter int CHIPS_PER_BIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic take,
  output logic at_last
);
  localparam int SW = (CHIPS_PER_BIT > 2) ? $clog2(CHIPS_PER_BIT) : 1;
  localparam logic [SW-1:0] LAST = SW'(CHIPS_PER_BIT - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= LAST;
    end else if (adv) begin
      if (slot_q == LAST) begin
        if (take) slot_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign at_last = (slot_q == LAST);
endmodule

// File: rtl/transition_marker.sv
module transition_marker (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic bit_in,
  output logic flip
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst)       prev_q <= 1'b0;
    else if (take) prev_q <= bit_in;
  end

  assign flip = bit_in ^ prev_q;
endmodule

// File: rtl/chip_out_stage.sv
module chip_out_stage
  import bpsk_enc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     adv,
  input  logic     at_last,
  input  grp_evt_t evt,
  output logic     chip_q,
  output logic     busy_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chip_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (adv) begin
      chip_q <= evt.take & evt.flip;
      if (at_last) busy_q <= evt.take;
    end
  end
endmodule

// File: rtl/bpsk_chip_encoder.sv
module bpsk_chip_encoder
  import bpsk_enc_pkg::*;
#(
  parameter int CHIPS_PER_BIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  input  logic sym_en,
  output logic sym_out,
  output logic busy
);
  logic     at_last;
  logic     flip;
  grp_evt_t evt;

  assign in_ready = sym_en & at_last;
  assign evt.take = in_ready & in_valid;
  assign evt.flip = flip;

  chip_slot_counter #(.CHIPS_PER_BIT(CHIPS_PER_BIT)) u_slot (
    .clk(clk), .rst(rst), .adv(sym_en), .take(evt.take), .at_last(at_last)
  );

  transition_marker u_mark (
    .clk(clk), .rst(rst), .take(evt.take), .bit_in(in_bit), .flip(flip)
  );

  chip_out_stage u_out (
    .clk(clk), .rst(rst), .adv(sym_en), .at_last(at_last), .evt(evt),
    .chip_q(sym_out), .busy_q(busy)
  );
endmodule

// File: rtl/bpsk_chip_encoder_chk.sv
module bpsk_chip_encoder_chk #(
  parameter int CHIPS_PER_BIT = 10
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic sym_en,
  input logic sym_out,
  input logic busy
);
  localparam int CW = (CHIPS_PER_BIT > 2) ? $clog2(CHIPS_PER_BIT) : 1;
  localparam logic [CW-1:0] CLAST = CW'(CHIPS_PER_BIT - 1);

  // Enables seen since the last accepted bit, saturating at the group end
  logic [CW-1:0] since_take;
  always_ff @(posedge clk) begin
    if (rst)                         since_take <= CLAST;
    else if (in_valid && in_ready)   since_take <= '0;
    else if (sym_en && since_take != CLAST) since_take <= since_take + 1'b1;
  end

  // R2
  ready_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> sym_en);

  // R9
  ready_at_group_end_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> since_take == CLAST);

  // R5
  one_chip_first_slot_chk: assert property (@(posedge clk) disable iff (rst)
    sym_out |-> (since_take == '0 && busy));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sym_out);

  // R8
  hold_without_en_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_en |=> ($stable(sym_out) && $stable(busy)));
endmodule

bind bpsk_chip_encoder bpsk_chip_encoder_chk #(.CHIPS_PER_BIT(CHIPS_PER_BIT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .sym_en(sym_en), .sym_out(sym_out), .busy(busy)
);

// File: tb/tb_bpsk_chip_encoder.sv
`timescale 1ns/1ps
module tb_bpsk_chip_encoder;
  localparam int N = 10;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_bit = 0, sym_en = 0;
  logic in_ready, sym_out, busy;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  int mslot = N - 1;
  bit mbusy = 0, mprev = 0, mout = 0;
  int pulses = 0;

  always #2 clk = ~clk;  // 250 MHz

  bpsk_chip_encoder #(.CHIPS_PER_BIT(N)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .sym_en(sym_en), .sym_out(sym_out), .busy(busy)
  );

  function automatic bit exp_ready(bit en);
    return en && (mslot == N - 1);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit en, bit v, bit b);
    string tag;
    bit r;
    @(negedge clk);
    sym_en = en; in_valid = v; in_bit = b;
    #1;
    r = exp_ready(en);
    chk("R2 in_ready", in_ready, r);
    tag = "R8 hold";
    if (en) begin
      if (r) begin
        if (v) begin
          mout = (b != mprev);
          tag = mout ? "R3 flip chip" : "R4 no flip";
          mprev = b; mslot = 0; mbusy = 1;
        end else begin
          mout = 0; mbusy = 0; tag = "R7 idle";
        end
      end else begin
        mslot++; mout = 0; tag = "R5 later slot";
      end
    end
    @(posedge clk); #1;
    chk(tag, sym_out, mout);
    chk("R9 busy", busy, mbusy);
    if (sym_out) pulses++;
  endtask

  // one full data bit, enable every cycle
  task automatic send_bit(bit b);
    step(1, 1, b);
    for (int k = 1; k < N; k++) step(1, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit pat[8];
    int trans;
    void'($urandom(32'd7719));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; sym_en = 1; #1;
    chk("R1 sym_out", sym_out, 0);
    chk("R1 busy", busy, 0);
    chk("R1 in_ready", in_ready, 1);
    sym_en = 0;

    // R6: first bit 1 after reset gives a chip of 1
    step(1, 1, 1);
    chk("R6 first one", sym_out, 1);
    for (int k = 1; k < N; k++) step(1, 0, 0);

    // directed pattern, counting pulses against transitions (R3, R4)
    pat = '{1, 1, 0, 1, 0, 0, 0, 1};
    pulses = 0; trans = 0;
    for (int i = 0; i < 8; i++) begin
      if (pat[i] != mprev) trans++;
      send_bit(pat[i]);
    end
    chk("R3 pulse count", pulses == trans, 1);

    // R7: idle gap, then resume with the same bit -> no chip of 1
    repeat (5) step(1, 0, 0);
    chk("R7 idle busy", busy, 0);
    step(1, 1, mprev);
    chk("R7 resume same", sym_out, 0);
    for (int k = 1; k < N; k++) step(1, 0, 0);

    // R8: sparse enables with data held valid
    for (int k = 0; k < 3 * N; k++) step(k % 3 == 0, 1, 1'(k / N));

    // random mix
    for (int k = 0; k < 4000; k++)
      step(($urandom % 3) == 0, ($urandom % 4) != 0, 1'($urandom));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule